// File: doc/BRIEF.md
# Fence-Ordered Store Buffer

This unit sits between one processor request port and a single-ported memory. Stores are parked in a small first-in first-out buffer and written to memory in the background. A later load can go to memory before those parked stores. When the load's address matches a parked store, the load is answered from the buffer and does not go to memory. Without fences, memory sees accesses out of program order. The requester still sees program-order values for its own addresses.

A fence op restores ordering when software needs it. A full fence waits for every earlier access. A load fence waits only for loads. A store fence waits only for stores. A region fence waits only for stores whose address falls inside a parameterised address window. A fence costs cycles only when one is issued.

The requester side uses valid/ready with a two-bit op, a two-bit fence kind, an address and write data, plus a response strobe carrying load data. The memory side holds a request with a write enable until the memory acknowledges it.

Top module: `fence_store_buffer`

## Requirements
- R1: After reset the buffer is empty and no fence is pending. `reqReady` is 1, and `memReq` and `rspValid` are 0.
- R2: Op code 1 is a store. A store is accepted in the same cycle it is offered whenever fewer than `DEPTH` (default 4) stores are buffered, so stores can be accepted every cycle.
- R3: Buffered stores are written to memory in acceptance order, one per `memAck`. `memReq`, `memWe` and `memAddr` stay stable from the cycle `memReq` rises until the cycle `memAck` is seen. After all stores drain, each address holds the value of its last store.
- R4: While `DEPTH` stores are buffered, `reqReady` is 0 whenever the offered op is a store.
- R5: Op code 0 is a load. A load whose address matches a buffered store is accepted without waiting, even when the buffer is full. `rspValid` pulses in the next cycle, and `rspData` carries the data of the youngest matching store.
- R6: A load that matches no buffered store goes to memory ahead of every buffered store not yet presented to memory. A store already presented to memory completes first. `reqReady` stays 0 until that load's response.
- R7: An op with bit 1 set is a fence, and `reqKind` selects the fence kind. A full fence (kind 0) holds `reqReady` at 0 from the cycle after acceptance until the buffer is empty and no load is outstanding.
- R8: A load fence (kind 1) holds `reqReady` at 0 for exactly one cycle, whatever stores are buffered.
- R9: A store fence (kind 2) holds `reqReady` at 0 until every buffered store has been written.
- R10: A region fence (kind 3) holds `reqReady` at 0 only until no buffered store has an address in [`RGN_LO`, `RGN_HI`]. Stores outside that window may still be buffered when it completes.
- R11: Each load returns the value of the last earlier store to the same address. If there is no such store, it returns the memory contents. Responses come in load order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqOp | input | 2 | 0 load, 1 store, 2 or 3 fence |
| reqKind | input | 2 | Fence kind: 0 full, 1 loads, 2 stores, 3 region |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Store data |
| rspValid | output | 1 | Load response strobe |
| rspData | output | DATA_W | Load response data |
| memReq | output | 1 | Memory request held until acknowledge |
| memWe | output | 1 | Memory request is a write |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory acknowledge, with read data for loads |
| memRdata | input | DATA_W | Memory read data |

## Verification
Some internal faults show up quickly at the ports:
- A wrong head or tail pointer, or a wrong count, shows up within a few stores. Either a forwarded load returns stale or foreign data, or the final memory image differs from the program-order image once a full fence drains the buffer.
- A wrong fence completion condition shows up in the fence's own cycle. `reqReady` returns while the bench's count of written stores still lags the count of accepted stores, or a load fence stalls longer than one cycle.

Wrong arbitration shows up at the ports only on the next miss load, through the number of stores written before its response.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam logic [1:0] OP_LOAD  = 2'd0;
  localparam logic [1:0] OP_STORE = 2'd1;

  typedef enum logic [1:0] {
    FK_ALL    = 2'd0,
    FK_LOADS  = 2'd1,
    FK_STORES = 2'd2,
    FK_REGION = 2'd3
  } fenceKind_t;

  typedef enum logic [1:0] {
    MS_IDLE  = 2'd0,
    MS_LOAD  = 2'd1,
    MS_STORE = 2'd2
  } memState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic latchLoad;
    logic rspFwd;
    logic rspMem;
    logic selLoad;
  } sbStrobe_t;

endpackage

// File: rtl/fsb_datapath.sv
module fsb_datapath
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter logic [ADDR_W-1:0] RGN_LO = 16'h1000,
  parameter logic [ADDR_W-1:0] RGN_HI = 16'h1FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         str,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              full,
  output logic              empty,
  output logic              fwdHit,
  output logic              regionBusy,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] rspData
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [PTR_W-1:0]  head;
  logic [PTR_W-1:0]  tail;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] loadAddr;
  logic [DATA_W-1:0] fwdData;

  function automatic logic inRegion(input logic [ADDR_W-1:0] a);
    return (a >= RGN_LO) && (a <= RGN_HI);
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (str.push) begin
      entAddr[tail] <= reqAddr;
      entData[tail] <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (str.push) tail <= tail + 1'b1;
      if (str.pop)  head <= head + 1'b1;
      count <= count + CNT_W'(str.push) - CNT_W'(str.pop);
    end
  end

  // scan oldest to youngest so the youngest match wins
  always_comb begin
    fwdHit  = 1'b0;
    fwdData = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count) && (entAddr[head + PTR_W'(i)] == reqAddr)) begin
        fwdHit  = 1'b1;
        fwdData = entData[head + PTR_W'(i)];
      end
    end
  end

  always_comb begin
    regionBusy = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count) && inRegion(entAddr[head + PTR_W'(i)])) regionBusy = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadAddr <= '0;
      rspData  <= '0;
    end else begin
      if (str.latchLoad) loadAddr <= reqAddr;
      if (str.rspFwd)      rspData <= fwdData;
      else if (str.rspMem) rspData <= memRdata;
    end
  end

  assign memAddr  = str.selLoad ? loadAddr : entAddr[head];
  assign memWdata = entData[head];

  // R4
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.push && full));

  // R3
  pop_has_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.pop |-> !empty);

endmodule

// File: rtl/fsb_control.sv
module fsb_control
  import fsb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqKind,
  input  logic       memAck,
  input  logic       full,
  input  logic       empty,
  input  logic       fwdHit,
  input  logic       regionBusy,
  output logic       reqReady,
  output logic       rspValid,
  output logic       memReq,
  output logic       memWe,
  output sbStrobe_t  str
);

  logic       loadWaiting;
  logic       fenceActive;
  fenceKind_t fenceKind;
  memState_t  memState;
  logic       isLoad, isStore, isFence, accept, fenceDone;

  assign isLoad  = (reqOp == OP_LOAD);
  assign isStore = (reqOp == OP_STORE);
  assign isFence = reqOp[1];

  assign reqReady = !loadWaiting && !fenceActive && !(isStore && full);
  assign accept   = reqValid && reqReady;

  always_comb begin
    unique case (fenceKind)
      FK_ALL:    fenceDone = empty && !loadWaiting;
      FK_LOADS:  fenceDone = !loadWaiting;
      FK_STORES: fenceDone = empty;
      FK_REGION: fenceDone = !regionBusy;
      default:   fenceDone = 1'b1;
    endcase
  end

  always_comb begin
    str           = '0;
    str.push      = accept && isStore;
    str.latchLoad = accept && isLoad && !fwdHit;
    str.rspFwd    = accept && isLoad && fwdHit;
    str.rspMem    = (memState == MS_LOAD) && memAck;
    str.pop       = (memState == MS_STORE) && memAck;
    str.selLoad   = (memState == MS_LOAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadWaiting <= 1'b0;
      fenceActive <= 1'b0;
      fenceKind   <= FK_ALL;
      rspValid    <= 1'b0;
    end else begin
      rspValid <= str.rspFwd || str.rspMem;
      if (str.latchLoad)   loadWaiting <= 1'b1;
      else if (str.rspMem) loadWaiting <= 1'b0;
      if (accept && isFence) begin
        fenceActive <= 1'b1;
        fenceKind   <= fenceKind_t'(reqKind);
      end else if (fenceActive && fenceDone) begin
        fenceActive <= 1'b0;
      end
    end
  end

  // a waiting load wins the idle port over the buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memState <= MS_IDLE;
    end else begin
      unique case (memState)
        MS_IDLE: begin
          if (loadWaiting)  memState <= MS_LOAD;
          else if (!empty)  memState <= MS_STORE;
        end
        MS_LOAD:  if (memAck) memState <= MS_IDLE;
        MS_STORE: if (memAck) memState <= MS_IDLE;
        default:  memState <= MS_IDLE;
      endcase
    end
  end

  assign memReq = (memState != MS_IDLE);
  assign memWe  = (memState == MS_STORE);

  // R7
  fence_blocks_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isFence) |=> !reqReady);

  // R7
  full_fence_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(fenceActive) && fenceKind == FK_ALL) |-> (empty && !loadWaiting));

  // R9
  store_fence_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(fenceActive) && fenceKind == FK_STORES) |-> empty);

  // R10
  region_fence_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(fenceActive) && fenceKind == FK_REGION) |-> !regionBusy);

endmodule

// File: rtl/fence_store_buffer.sv
module fence_store_buffer
  import fsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter logic [ADDR_W-1:0] RGN_LO = 16'h1000,
  parameter logic [ADDR_W-1:0] RGN_HI = 16'h1FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqOp,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);

  sbStrobe_t str;
  logic full, empty, fwdHit, regionBusy;

  fsb_control i_control (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqKind(reqKind),
    .memAck(memAck), .full(full), .empty(empty), .fwdHit(fwdHit),
    .regionBusy(regionBusy), .reqReady(reqReady), .rspValid(rspValid),
    .memReq(memReq), .memWe(memWe), .str(str)
  );

  fsb_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .RGN_LO(RGN_LO), .RGN_HI(RGN_HI)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .str(str), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memRdata(memRdata), .full(full), .empty(empty), .fwdHit(fwdHit),
    .regionBusy(regionBusy), .memAddr(memAddr), .memWdata(memWdata), .rspData(rspData)
  );

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

// File: tb/test_fence_store_buffer.sv
module test_fence_store_buffer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqReady;
  logic [1:0]  reqOp, reqKind;
  logic [15:0] reqAddr, memAddr;
  logic [31:0] reqWdata, rspData, memWdata, memRdata;
  logic        rspValid, memReq, memWe, memAck;

  always #10 clk = ~clk;

  fence_store_buffer i_fence_store_buffer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspData(rspData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] memArr [256];
  logic [31:0] shadow [256];
  logic [31:0] expQ [$];
  int writes = 0, regWrites = 0, storesAcc = 0, regAcc = 0;
  bit memStall = 0, fastMem = 1;

  function automatic int ix(input logic [15:0] a);
    return int'({a[12], a[6:0]});
  endfunction

  function automatic bit inRgn(input logic [15:0] a);
    return (a >= 16'h1000) && (a <= 16'h1FFF);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // memory model: acknowledges on a falling edge, held one cycle
  always @(negedge clk) begin
    if (!rstN) memAck = 1'b0;
    else if (memAck) memAck = 1'b0;
    else if (memReq && !memStall && (fastMem || ($urandom % 3) == 0)) begin
      memAck = 1'b1;
      if (memWe) begin
        memArr[ix(memAddr)] = memWdata;
        writes++;
        if (inRgn(memAddr)) regWrites++;
      end else begin
        memRdata = memArr[ix(memAddr)];
      end
    end
  end

  // R11 response monitor
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) chk(1'b0, "R11 unexpected response", rspData, 32'h0);
      else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk(rspData == e, "R11 load data", rspData, e);
      end
    end
  end

  task automatic doOp(input logic [1:0] op, input logic [1:0] kind, input logic [15:0] a,
                      input logic [31:0] d, output int stalls);
    stalls = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqKind = kind; reqAddr = a; reqWdata = d;
    #1;
    while (!reqReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    if (op == 2'd0) expQ.push_back(shadow[ix(a)]);
    else if (op == 2'd1) begin
      shadow[ix(a)] = d;
      storesAcc++;
      if (inRgn(a)) regAcc++;
    end
  endtask

  task automatic fenceOp(input logic [1:0] kind, input int releaseAfter, output int low);
    int s;
    doOp(2'd2, kind, 16'h0, 32'h0, s);
    low = 0;
    forever begin
      @(negedge clk);
      #1;
      if (reqReady) break;
      low++;
      if (releaseAfter > 0 && low == releaseAfter) memStall = 0;
    end
    case (kind)
      2'd0: chk(writes == storesAcc, "R7 full fence drained", writes, storesAcc);
      2'd1: chk(low == 1, "R8 load fence one cycle", low, 1);
      2'd2: chk(writes == storesAcc, "R9 store fence drained", writes, storesAcc);
      default: chk(regWrites == regAcc, "R10 region stores drained", regWrites, regAcc);
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      endRun();
    end
  end

  initial begin
    int s, low, tot, w0, guard;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      memArr[i] = 32'hA500_0000 + i * 7;
      shadow[i] = memArr[i];
    end
    rstN = 1'b0; reqValid = 1'b0; reqOp = 2'd0; reqKind = 2'd0;
    reqAddr = '0; reqWdata = '0; memAck = 1'b0; memRdata = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    chk(memReq == 1'b0, "R1 no memory request", memReq, 0);
    chk(rspValid == 1'b0, "R1 no response", rspValid, 0);

    // R2 back-to-back stores
    tot = 0;
    for (int i = 0; i < 4; i++) begin
      doOp(2'd1, 2'd0, 16'h0010 + 16'(i * 4), 32'h1111_0000 + i, s);
      tot += s;
    end
    chk(tot == 0, "R2 stores without stall", tot, 0);
    fenceOp(2'd0, 0, low);

    // R4 and R5: fill with memory stalled, then forward
    memStall = 1;
    tot = 0;
    doOp(2'd1, 2'd0, 16'h0020, 32'hD1, s); tot += s;
    doOp(2'd1, 2'd0, 16'h0024, 32'hD2, s); tot += s;
    doOp(2'd1, 2'd0, 16'h0020, 32'hD3, s); tot += s;
    doOp(2'd1, 2'd0, 16'h0028, 32'hD4, s); tot += s;
    chk(tot == 0, "R2 fill four entries", tot, 0);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd1; reqAddr = 16'h002C; reqWdata = 32'hD5;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(reqReady == 1'b0, "R4 store stalls when full", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    doOp(2'd0, 2'd0, 16'h0020, 32'h0, s);
    chk(s == 0, "R5 forward load not stalled", s, 0);
    @(negedge clk);
    #1;
    chk(rspValid && rspData == 32'hD3, "R5 youngest match", rspData, 32'hD3);

    // R6 miss load passes unissued stores
    doOp(2'd0, 2'd0, 16'h0030, 32'h0, s);
    @(negedge clk);
    #1;
    chk(reqReady == 1'b0, "R6 blocked while load outstanding", reqReady, 0);
    w0 = writes;
    memStall = 0;
    guard = 0;
    do begin
      @(negedge clk);
      #1;
      guard++;
    end while (!rspValid && guard < 50);
    chk(writes == w0 + 1, "R6 only issued store before load", writes, w0 + 1);
    chk(rspData == memArr[ix(16'h0030)], "R6 load data from memory", rspData, memArr[ix(16'h0030)]);
    fenceOp(2'd0, 0, low);

    // R8 and R9
    memStall = 1;
    doOp(2'd1, 2'd0, 16'h0034, 32'hE1, s);
    doOp(2'd1, 2'd0, 16'h0038, 32'hE2, s);
    fenceOp(2'd1, 0, low);
    chk(writes < storesAcc, "R8 load fence left stores buffered", writes, storesAcc);
    fenceOp(2'd2, 4, low);
    chk(low > 4, "R9 store fence waited for drain", low, 5);

    // R10 region fence
    memStall = 1;
    doOp(2'd1, 2'd0, 16'h0040, 32'hF1, s);
    doOp(2'd1, 2'd0, 16'h0044, 32'hF2, s);
    fenceOp(2'd3, 0, low);
    chk(low == 1, "R10 region fence ignores outside stores", low, 1);
    chk(writes < storesAcc, "R10 outside stores still buffered", writes, storesAcc);
    doOp(2'd1, 2'd0, 16'h1040, 32'hF3, s);
    fenceOp(2'd3, 5, low);
    chk(low > 5, "R10 region fence waited", low, 6);
    fenceOp(2'd0, 0, low);

    // random mix
    fastMem = 0;
    for (int n = 0; n < 400; n++) begin
      int r, k;
      logic [15:0] a;
      r = int'($urandom % 20);
      k = int'($urandom % 8);
      a = (k < 4) ? 16'h0100 + 16'(k * 4) : 16'h1100 + 16'((k - 4) * 4);
      if (r < 8) doOp(2'd1, 2'd0, a, $urandom, s);
      else if (r < 17) doOp(2'd0, 2'd0, a, 32'h0, s);
      else fenceOp(2'($urandom % 4), 0, low);
    end
    fenceOp(2'd0, 0, low);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] a;
      a = (k < 4) ? 16'h0100 + 16'(k * 4) : 16'h1100 + 16'((k - 4) * 4);
      chk(memArr[ix(a)] == shadow[ix(a)], "R3 final memory image", memArr[ix(a)], shadow[ix(a)]);
    end
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R11 all loads answered", expQ.size(), 0);
    endRun();
  end

endmodule